// File: doc/BRIEF.md
# Interrupt priority vector resolver

This block takes two sets of interrupt candidates and returns, for each set, the single source a handler should serve next. The normal set is settled by priority. Each of the 64 sources carries a 4-bit priority level. The source with the largest level wins, and when several sources share that level the highest-numbered one wins. The fast set has no priority ordering: the lowest-numbered candidate wins.

Each winner is returned as a 32-bit vector status word. When a set holds no candidate, its word is all ones. The controller core around this block gates pending sources with their enables and types to form the two sets. The core also handles the bus and clears the winner when the word is read. This block is purely the selection datapath.

The resolver is a two-stage pipeline. The first stage reduces each group of sources to one local winner, using a tree of pairwise selectors. The second stage reduces the group winners to one and formats the status words. A result appears exactly two clock cycles after the inputs are presented with `in_valid`, and `out_valid` marks it.

Top module: `irq_vector_resolver`

## Requirements
- R1: The priority of source n is `prio_packed[4n+3:4n]`. This is 32-bit packed word n/8, bits 4·(n mod 8) upward.
- R2: The normal winner is the candidate with the largest priority value. Among candidates with equal priority, the higher source number wins.
- R3: A normal candidate whose priority is 0 still wins over having no candidate.
- R4: The normal status word carries the winning source number in bits 21:16 and its priority in bits 3:0. All other bits are zero.
- R5: The fast winner is the lowest-numbered set bit of `fast_cand`. The fast status word is that index, zero-extended to 32 bits. Priorities have no effect on it.
- R6: Each path independently returns 0xFFFF_FFFF when its candidate set is empty.
- R7: `out_valid` equals `in_valid` delayed by exactly two clock edges. The status words then reflect the inputs sampled together with that `in_valid`, and back-to-back inputs are accepted every cycle.
- R8: While reset is active and right after it, `out_valid` is 0 and both status words are 0xFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inputs in this cycle are to be resolved |
| normal_cand | input | 64 | Normal candidate set, one bit per source |
| fast_cand | input | 64 | Fast candidate set, one bit per source |
| prio_packed | input | 256 | 4-bit priority of every source, source n at bits 4n+3:4n |
| out_valid | output | 1 | Status words hold a result |
| normal_status | output | 32 | Normal winner: source in 21:16, priority in 3:0, or all ones |
| fast_status | output | 32 | Fast winner index zero-extended, or all ones |

## Verification
The assertions that compare a result with inputs from two cycles earlier take for granted that `in_valid` stays low while reset is held, so the delayed inputs they read belong to a real request. The stimulus keeps to this: it holds every input at zero through reset and changes inputs only on the falling clock edge. The assertions do not require the sets to be disjoint or the inputs to be stable between requests. The random phase therefore drives independent candidate sets and fresh priorities on every cycle, including back-to-back valid cycles and cycles with `in_valid` low.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    // Status word layout shared with the controller core.
    localparam int STAT_W  = 32;
    localparam int SRC_LSB = 16;
    localparam logic [STAT_W-1:0] STAT_NONE = '1;
endpackage

// File: rtl/ivr_norm_tree.sv
// Pairwise max-priority tree. Leaves are ordered by ascending source
// number, so the right child always holds the higher numbers. The right
// child is taken on a tie, which matches a linear scan that keeps the
// last equal-or-better entry.
module ivr_norm_tree #(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = 6
) (
    input  logic [N-1:0]         vld_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    input  logic [N-1:0][IW-1:0] idx_i,
    output logic                 vld_o,
    output logic [PW-1:0]        prio_o,
    output logic [IW-1:0]        idx_o
);
    localparam int NODES = 2 * N - 1;

    logic [NODES-1:0]         node_v;
    logic [NODES-1:0][PW-1:0] node_p;
    logic [NODES-1:0][IW-1:0] node_i;

    for (genvar l = 0; l < N; l++) begin : g_leaf
        assign node_v[N-1+l] = vld_i[l];
        assign node_p[N-1+l] = prio_i[l];
        assign node_i[N-1+l] = idx_i[l];
    end

    for (genvar j = 0; j < N - 1; j++) begin : g_node
        logic take_right;
        assign take_right = node_v[2*j+2] &&
                            (!node_v[2*j+1] || node_p[2*j+2] >= node_p[2*j+1]);
        assign node_v[j] = node_v[2*j+1] | node_v[2*j+2];
        assign node_p[j] = take_right ? node_p[2*j+2] : node_p[2*j+1];
        assign node_i[j] = take_right ? node_i[2*j+2] : node_i[2*j+1];
    end

    assign vld_o  = node_v[0];
    assign prio_o = node_p[0];
    assign idx_o  = node_i[0];
endmodule

// File: rtl/ivr_fast_scan.sv
// Lowest set bit finder.
module ivr_fast_scan #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  bits_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) idx_o = IW'(i);
        end
        any_o = |bits_i;
    end
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
    import ivr_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int GROUPS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NUM_SRC-1:0]        normal_cand,
    input  logic [NUM_SRC-1:0]        fast_cand,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_packed,
    output logic                      out_valid,
    output logic [STAT_W-1:0]         normal_status,
    output logic [STAT_W-1:0]         fast_status
);
    localparam int IDX_W  = $clog2(NUM_SRC);
    localparam int GRP_SZ = NUM_SRC / GROUPS;
    localparam int LOC_W  = $clog2(GRP_SZ);
    localparam int GRP_W  = $clog2(GROUPS);

    typedef struct packed {
        logic                           vld;
        logic [GROUPS-1:0]              n_any;
        logic [GROUPS-1:0][PRIO_W-1:0]  n_prio;
        logic [GROUPS-1:0][IDX_W-1:0]   n_idx;
        logic [GROUPS-1:0]              f_any;
        logic [GROUPS-1:0][IDX_W-1:0]   f_idx;
    } stage1_t;

    typedef struct packed {
        logic              vld;
        logic [STAT_W-1:0] nstat;
        logic [STAT_W-1:0] fstat;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    // ---------------- stage 1: per-group reduction ----------------
    logic [GROUPS-1:0]             grp_n_any;
    logic [GROUPS-1:0][PRIO_W-1:0] grp_n_prio;
    logic [GROUPS-1:0][IDX_W-1:0]  grp_n_idx;
    logic [GROUPS-1:0]             grp_f_any;
    logic [GROUPS-1:0][LOC_W-1:0]  grp_f_loc;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [GRP_SZ-1:0][PRIO_W-1:0] leaf_prio;
        logic [GRP_SZ-1:0][IDX_W-1:0]  leaf_idx;

        for (genvar i = 0; i < GRP_SZ; i++) begin : g_leaf
            assign leaf_prio[i] = prio_packed[(g*GRP_SZ+i)*PRIO_W +: PRIO_W];
            assign leaf_idx[i]  = IDX_W'(g*GRP_SZ + i);
        end

        ivr_norm_tree #(.N(GRP_SZ), .PW(PRIO_W), .IW(IDX_W)) i_norm (
            .vld_i  (normal_cand[g*GRP_SZ +: GRP_SZ]),
            .prio_i (leaf_prio),
            .idx_i  (leaf_idx),
            .vld_o  (grp_n_any[g]),
            .prio_o (grp_n_prio[g]),
            .idx_o  (grp_n_idx[g])
        );

        ivr_fast_scan #(.N(GRP_SZ), .IW(LOC_W)) i_fast (
            .bits_i (fast_cand[g*GRP_SZ +: GRP_SZ]),
            .any_o  (grp_f_any[g]),
            .idx_o  (grp_f_loc[g])
        );
    end

    always_comb begin
        s1_d.vld    = in_valid;
        s1_d.n_any  = grp_n_any;
        s1_d.n_prio = grp_n_prio;
        s1_d.n_idx  = grp_n_idx;
        s1_d.f_any  = grp_f_any;
        for (int g = 0; g < GROUPS; g++) begin
            s1_d.f_idx[g] = IDX_W'(g * GRP_SZ) + IDX_W'(grp_f_loc[g]);
        end
    end

    // ---------------- stage 2: across groups, format ----------------
    logic [GROUPS-1:0][IDX_W-1:0] top_leaf_idx;
    logic                         top_n_vld;
    logic [PRIO_W-1:0]            top_n_prio;
    logic [IDX_W-1:0]             top_n_idx;
    logic                         top_f_any;
    logic [GRP_W-1:0]             top_f_grp;

    assign top_leaf_idx = s1_q.n_idx;

    ivr_norm_tree #(.N(GROUPS), .PW(PRIO_W), .IW(IDX_W)) i_norm_top (
        .vld_i  (s1_q.n_any),
        .prio_i (s1_q.n_prio),
        .idx_i  (top_leaf_idx),
        .vld_o  (top_n_vld),
        .prio_o (top_n_prio),
        .idx_o  (top_n_idx)
    );

    ivr_fast_scan #(.N(GROUPS), .IW(GRP_W)) i_fast_top (
        .bits_i (s1_q.f_any),
        .any_o  (top_f_any),
        .idx_o  (top_f_grp)
    );

    always_comb begin
        s2_d.vld   = s1_q.vld;
        s2_d.nstat = STAT_NONE;
        s2_d.fstat = STAT_NONE;
        if (top_n_vld) begin
            s2_d.nstat                         = '0;
            s2_d.nstat[SRC_LSB +: IDX_W]       = top_n_idx;
            s2_d.nstat[PRIO_W-1:0]             = top_n_prio;
        end
        if (top_f_any) begin
            s2_d.fstat = STAT_W'(s1_q.f_idx[top_f_grp]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q       <= '0;
            s2_q.vld   <= 1'b0;
            s2_q.nstat <= STAT_NONE;
            s2_q.fstat <= STAT_NONE;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid     = s2_q.vld;
    assign normal_status = s2_q.nstat;
    assign fast_status   = s2_q.fstat;

    // ---------------- assertions ----------------
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2));

    a_r4_normal_format: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && normal_status != STAT_NONE) |->
        (normal_status[STAT_W-1:SRC_LSB+IDX_W] == '0 &&
         normal_status[SRC_LSB-1:PRIO_W] == '0));

    a_r1_prio_matches_source: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && normal_status != STAT_NONE) |->
        (PRIO_W'($past(prio_packed, 2) >> (PRIO_W * normal_status[SRC_LSB +: IDX_W]))
         == normal_status[PRIO_W-1:0]));

    a_r3_normal_from_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && normal_status != STAT_NONE) |->
        1'($past(normal_cand, 2) >> normal_status[SRC_LSB +: IDX_W]));

    a_r6_normal_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(normal_cand, 2) == '0) |-> normal_status == STAT_NONE);

    a_r5_fast_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fast_status != STAT_NONE) |->
        (fast_status < STAT_W'(NUM_SRC) &&
         1'($past(fast_cand, 2) >> fast_status[IDX_W-1:0]) &&
         (($past(fast_cand, 2) & ((NUM_SRC'(1) << fast_status[IDX_W-1:0]) - NUM_SRC'(1))) == '0)));
endmodule

// File: tb/test_irq_vector_resolver.sv
module test_irq_vector_resolver;
    localparam int NS = 64;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NS-1:0]     normal_cand = '0;
    logic [NS-1:0]     fast_cand = '0;
    logic [NS*PW-1:0]  prio_packed = '0;
    logic              out_valid;
    logic [31:0]       normal_status;
    logic [31:0]       fast_status;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    irq_vector_resolver i_irq_vector_resolver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .normal_cand(normal_cand), .fast_cand(fast_cand),
        .prio_packed(prio_packed), .out_valid(out_valid),
        .normal_status(normal_status), .fast_status(fast_status));

    always #10 clk = ~clk;

    // Behavioural reference: linear scans.
    function automatic logic [31:0] ref_normal(logic [NS-1:0] c, logic [NS*PW-1:0] p);
        int best = -1;
        int bp = -1;
        for (int n = 0; n < NS; n++) begin
            int pv;
            pv = int'(p[n*PW +: PW]);
            if (c[n] && pv >= bp) begin
                best = n;
                bp = pv;
            end
        end
        if (best < 0) return 32'hFFFF_FFFF;
        return (32'(best) << 16) | 32'(bp);
    endfunction

    function automatic logic [31:0] ref_fast(logic [NS-1:0] c);
        for (int n = 0; n < NS; n++) if (c[n]) return 32'(n);
        return 32'hFFFF_FFFF;
    endfunction

    // Two-deep expected pipeline, advanced on every rising edge.
    bit          pv0 = 0, pv1 = 0;
    logic [31:0] pn0, pn1, pf0, pf1;

    always @(posedge clk) begin
        if (!rst_n) begin
            pv0 = 0; pv1 = 0;
        end else begin
            pv1 = pv0; pn1 = pn0; pf1 = pf0;
            pv0 = in_valid;
            pn0 = ref_normal(normal_cand, prio_packed);
            pf0 = ref_fast(fast_cand);
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 out_valid", 32'(out_valid), 32'(pv1));
            if (pv1 && out_valid) begin
                check("R2 normal_status", normal_status, pn1);
                check("R5 fast_status", fast_status, pf1);
            end
        end
    end

    task automatic apply(logic [NS-1:0] nc, logic [NS-1:0] fc, logic [NS*PW-1:0] pr);
        @(negedge clk);
        normal_cand = nc; fast_cand = fc; prio_packed = pr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [NS*PW-1:0] one_prio(int n, int v);
        logic [NS*PW-1:0] r = '0;
        r[n*PW +: PW] = PW'(v);
        return r;
    endfunction

    initial begin
        #200000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [NS*PW-1:0] pr;
        repeat (3) @(negedge clk);
        // R8: reset values while reset held
        check("R8 reset out_valid", 32'(out_valid), 32'h0);
        check("R8 reset normal_status", normal_status, 32'hFFFF_FFFF);
        check("R8 reset fast_status", fast_status, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset out_valid", 32'(out_valid), 32'h0);

        // R3: lone candidate with priority 0
        apply(64'h20, 64'h0, '0);
        check("R3 prio0 candidate", normal_status, 32'h0005_0000);
        check("R6 fast empty", fast_status, 32'hFFFF_FFFF);

        // R2: equal priorities, higher source wins
        pr = one_prio(3, 7) | one_prio(40, 7);
        apply((64'h1 << 3) | (64'h1 << 40), 64'h0, pr);
        check("R2 tie to higher index", normal_status, 32'h0028_0007);

        // R2: larger priority beats higher number
        pr = one_prio(63, 2) | one_prio(0, 15);
        apply((64'h1 << 63) | 64'h1, 64'h0, pr);
        check("R2 max priority", normal_status, 32'h0000_000F);

        // R1 and R4: packed position of source 17 (word 2, bits 7:4)
        pr = one_prio(17, 9);
        apply((64'h1 << 17) | (64'h1 << 16), 64'h0, pr);
        check("R1 priority position", normal_status, 32'h0011_0009);
        check("R4 format", normal_status & 32'hFFC0_FFF0, 32'h0);

        // R5: fast lowest index, priorities irrelevant
        apply(64'h0, (64'h1 << 63) | (64'h1 << 9), {NS{4'hF}});
        check("R5 fast lowest", fast_status, 32'd9);
        check("R6 normal empty", normal_status, 32'hFFFF_FFFF);
        apply(64'h0, 64'h1 << 63, '0);
        check("R5 fast top index", fast_status, 32'd63);

        // R7: single pulse timing
        @(negedge clk);
        normal_cand = 64'h1; fast_cand = 64'h0; prio_packed = '0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; normal_cand = '0;
        check("R7 one edge later", 32'(out_valid), 32'h0);
        @(negedge clk);
        check("R7 two edges later", 32'(out_valid), 32'h1);
        check("R7 sampled data", normal_status, 32'h0000_0000);
        @(negedge clk);
        check("R7 pulse ends", 32'(out_valid), 32'h0);

        // Random back-to-back traffic, compared by the model every cycle.
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            normal_cand = {$urandom, $urandom} & {$urandom, $urandom} &
                          (($urandom % 5 == 0) ? 64'h0 : {$urandom, $urandom});
            fast_cand = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom % 6 == 0) fast_cand = '0;
            for (int w = 0; w < NS*PW/32; w++) prio_packed[w*32 +: 32] = $urandom;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule